// File: doc/BRIEF.md
# DRAM Row Access Sequencer with Bank Model

This block pairs a cycle-timed control sequencer with a behavioural model of one square DRAM bank. It is meant for verifying the logic of memory controllers. A host issues a read, a write or a refresh. The address reaches the block in two halves on one shared port. The row half comes first, with the request. The column half follows on the next cycle.

Every access walks the same fixed chain of phases: precharge, row activation, sensing, a single column access and a restore. Each phase lasts a parameterised number of cycles. Opening a row copies it into a row buffer and drains the stored cells, so the data survives only if the restore phase writes the buffer back. A write changes one word in the buffer and then writes the whole row back.

A refresh runs the same chain without the column half and without the column access. While an operation is in flight the block reports itself busy and ignores new requests. Charge sharing and sense amplification are not modelled electrically; they appear only as timed phases.

Top module: `dram_row_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge `busy` is 0, `phase` is 0 and `rd_valid` is 0, and every stored word of the bank is zero.
- R2: In idle, a request is taken at the clock edge where `req_valid` is 1. At that edge `addr` gives the row and `req_write` gives the direction. At the following edge `addr` gives the column and `wdata` gives the write data.
- R3: A host request shows these `phase` codes, in this order and for these durations: 1 (column capture) for 1 cycle, 2 (precharge) for T_PRE cycles, 3 (activate) for T_ACT cycles, 4 (sense) for T_SENSE cycles, 5 (column access) for 1 cycle, then 6 (restore) for T_RESTORE cycles. No phase is ever skipped. Code 0 means idle.
- R4: A read produces exactly one `rd_valid` pulse, lasting one cycle, during the first restore cycle. In that cycle `rd_data` holds the stored word at the addressed row and column.
- R5: Opening a row drains its stored words, and the restore phase writes them back. Repeated reads of the same location therefore keep returning the same word.
- R6: A write replaces only the addressed column of the row. Every other column of that row reads back unchanged afterwards.
- R7: `busy` is 1 from the cycle after the request is taken until the last restore cycle, inclusive. For a host operation that is 2+T_PRE+T_ACT+T_SENSE+T_RESTORE cycles; for a refresh it is T_PRE+T_ACT+T_SENSE+T_RESTORE cycles.
- R8: `req_valid` and `refresh_req` have no effect while `busy` is 1. A write requested during an operation and withdrawn before the operation ends changes no stored word.
- R9: When `refresh_req` is 1 in idle, `addr` gives the row. The block then runs phase codes 2, 3, 4 and 6 with the R3 durations, skipping codes 1 and 5. It produces no `rd_valid` and the row's contents are kept. If `refresh_req` and `req_valid` arrive together, the refresh wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request strobe, taken only in idle |
| req_write | input | 1 | 1 = write, 0 = read, sampled with the row half |
| refresh_req | input | 1 | Refresh request for the row on `addr` |
| addr | input | AB | Multiplexed address: row half, then column half |
| wdata | input | DW | Write data, sampled with the column half |
| busy | output | 1 | Operation in flight |
| phase | output | 3 | Current phase code (see R3) |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DW | Read data |

## Verification
The bench builds an 8x8 bank of 8-bit words with T_PRE=2, T_ACT=1, T_SENSE=2 and T_RESTORE=4. With T_ACT=1, a one-cycle timed phase is exercised next to multi-cycle ones. With T_RESTORE at twice T_SENSE, a write-back that fires early or late would be visible. With a row distinct from its column, (2,5) and (5,2) tell a swapped address half apart. The small bank lets a full row be filled, overwritten in one column and read back column by column against a reference array.

// File: rtl/drs_pkg.sv
// Package: shared phase encoding for the DRAM row sequencer.
// Assumes: phase codes are visible on the top-level port and must stay fixed.
package drs_pkg;
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_COL     = 3'd1,
        PH_PRE     = 3'd2,
        PH_ACT     = 3'd3,
        PH_SENSE   = 3'd4,
        PH_ACCESS  = 3'd5,
        PH_RESTORE = 3'd6
    } drs_phase_e;
endpackage

// File: rtl/drs_phase_timer.sv
// Module: down-counter that times the dwell of one sequencer phase.
// Assumes: start is pulsed on entry to a phase with dur >= 1; done is high
// in the last cycle of that phase.
module drs_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] dur,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Load the remaining cycles on entry, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (start)       cnt <= dur - 1'b1;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    AST_TMR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> dur != '0); // R3
endmodule

// File: rtl/drs_ctrl.sv
// Module: phase sequencer. Captures the row half of the address with the
// request and the column half one cycle later, then steps through
// precharge, activate, sense, column access and restore.
// Assumes: each timed phase parameter is >= 1 and fits in CW bits.
module drs_ctrl
    import drs_pkg::*;
#(
    parameter int AB        = 3,
    parameter int DW        = 8,
    parameter int CW        = 4,
    parameter int T_PRE     = 2,
    parameter int T_ACT     = 1,
    parameter int T_SENSE   = 2,
    parameter int T_RESTORE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          refresh_req,
    input  logic [AB-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          tmr_done,
    output logic          tmr_start,
    output logic [CW-1:0] tmr_dur,
    output drs_phase_e    state,
    output logic          busy,
    output logic [AB-1:0] row_q,
    output logic [AB-1:0] col_q,
    output logic          wr_q,
    output logic [DW-1:0] wdata_q,
    output logic          load_row,
    output logic          access_en,
    output logic          write_back
);
    localparam logic [CW-1:0] D_ONE   = CW'(1);
    localparam logic [CW-1:0] D_PRE   = CW'(T_PRE);
    localparam logic [CW-1:0] D_ACT   = CW'(T_ACT);
    localparam logic [CW-1:0] D_SENSE = CW'(T_SENSE);
    localparam logic [CW-1:0] D_RST   = CW'(T_RESTORE);
    localparam logic [CW:0]   W_PRE   = (CW+1)'(T_PRE);
    localparam logic [CW:0]   W_ACT   = (CW+1)'(T_ACT);
    localparam logic [CW:0]   W_SENSE = (CW+1)'(T_SENSE);
    localparam logic [CW:0]   W_RST   = (CW+1)'(T_RESTORE);

    drs_phase_e nxt;
    logic       is_ref;
    logic [CW:0] dwell;

    // Next-phase selection: fixed order, refresh skips the column steps.
    always_comb begin
        nxt = state;
        unique case (state)
            PH_IDLE:    if (refresh_req) nxt = PH_PRE;
                        else if (req_valid) nxt = PH_COL;
            PH_COL:     nxt = PH_PRE;
            PH_PRE:     if (tmr_done) nxt = PH_ACT;
            PH_ACT:     if (tmr_done) nxt = PH_SENSE;
            PH_SENSE:   if (tmr_done) nxt = is_ref ? PH_RESTORE : PH_ACCESS;
            PH_ACCESS:  nxt = PH_RESTORE;
            PH_RESTORE: if (tmr_done) nxt = PH_IDLE;
            default:    nxt = PH_IDLE;
        endcase
    end

    // Timer load on every phase entry, duration chosen by the new phase.
    always_comb begin
        tmr_start = (nxt != state) && (nxt != PH_IDLE);
        unique case (nxt)
            PH_PRE:     tmr_dur = D_PRE;
            PH_ACT:     tmr_dur = D_ACT;
            PH_SENSE:   tmr_dur = D_SENSE;
            PH_RESTORE: tmr_dur = D_RST;
            default:    tmr_dur = D_ONE;
        endcase
    end

    // Phase register and capture of the two address halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PH_IDLE;
            is_ref  <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            state <= nxt;
            if (state == PH_IDLE) begin
                if (refresh_req) begin
                    is_ref <= 1'b1;
                    row_q  <= addr;
                    wr_q   <= 1'b0;
                end else if (req_valid) begin
                    is_ref <= 1'b0;
                    row_q  <= addr;
                    wr_q   <= req_write;
                end
            end
            if (state == PH_COL) begin
                col_q   <= addr;
                wdata_q <= wdata;
            end
        end
    end

    // Cycles spent in the current phase, used only by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n)              dwell <= '0;
        else if (nxt != state)   dwell <= '0;
        else if (dwell != '1)    dwell <= dwell + 1'b1;
    end

    assign busy       = (state != PH_IDLE);
    assign load_row   = (state == PH_SENSE) && tmr_done;
    assign access_en  = (state == PH_ACCESS);
    assign write_back = (state == PH_RESTORE) && tmr_done;

    AST_PRE_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PH_PRE && state != PH_PRE) |-> state == PH_ACT); // R3
    AST_ACT_TO_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PH_ACT && state != PH_ACT) |-> state == PH_SENSE); // R3
    AST_PRE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PH_PRE && state != PH_PRE) |-> $past(dwell) + 1'b1 == W_PRE); // R3
    AST_ACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PH_ACT && state != PH_ACT) |-> $past(dwell) + 1'b1 == W_ACT); // R3
    AST_SENSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PH_SENSE && state != PH_SENSE) |-> $past(dwell) + 1'b1 == W_SENSE); // R3
    AST_RESTORE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PH_RESTORE && state != PH_RESTORE) |-> $past(dwell) + 1'b1 == W_RST); // R5
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_COL) |-> $past(state) == PH_IDLE); // R8
    AST_REFRESH_NO_COL: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (state != PH_ACCESS && state != PH_COL)); // R9
endmodule

// File: rtl/drs_bank.sv
// Module: behavioural square bank with a row buffer. Opening a row moves
// it into the buffer and drains the cells; the write-back restores it.
// Assumes: load, access and write-back arrive in that order, one row at a time.
module drs_bank #(
    parameter int AB = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AB-1:0] row,
    input  logic [AB-1:0] col,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          load_row,
    input  logic          access_en,
    input  logic          write_back,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    localparam int N = 1 << AB;

    logic [DW-1:0] mem    [N][N];
    logic [DW-1:0] rowbuf [N];
    logic          row_open;

    // Cell array, row buffer and the read-out register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    mem[r][c] <= '0;
            for (int c = 0; c < N; c++) rowbuf[c] <= '0;
            row_open <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (load_row) begin
                for (int c = 0; c < N; c++) begin
                    rowbuf[c]   <= mem[row][c];
                    mem[row][c] <= '0;
                end
                row_open <= 1'b1;
            end
            if (access_en) begin
                if (wr) rowbuf[col] <= wdata;
                else begin
                    rd_data  <= rowbuf[col];
                    rd_valid <= 1'b1;
                end
            end
            if (write_back) begin
                for (int c = 0; c < N; c++) mem[row][c] <= rowbuf[c];
                row_open <= 1'b0;
            end
        end
    end

    AST_LOAD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        load_row |-> !row_open); // R5
    AST_WB_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        write_back |-> row_open); // R5
    AST_ACCESS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        access_en |-> row_open); // R6
endmodule

// File: rtl/dram_row_seq.sv
// Module: top of the DRAM row sequencer plus bank model.
// Assumes: host holds addr stable per half as described in the brief.
module dram_row_seq
    import drs_pkg::*;
#(
    parameter int AB        = 3,
    parameter int DW        = 8,
    parameter int T_PRE     = 2,
    parameter int T_ACT     = 1,
    parameter int T_SENSE   = 2,
    parameter int T_RESTORE = 4,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          refresh_req,
    input  logic [AB-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic [2:0]    phase,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    drs_phase_e    state;
    logic          tmr_start, tmr_done;
    logic [CW-1:0] tmr_dur;
    logic [AB-1:0] row_q, col_q;
    logic          wr_q, load_row, access_en, write_back;
    logic [DW-1:0] wdata_q;

    drs_ctrl #(.AB(AB), .DW(DW), .CW(CW), .T_PRE(T_PRE), .T_ACT(T_ACT),
               .T_SENSE(T_SENSE), .T_RESTORE(T_RESTORE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .refresh_req(refresh_req), .addr(addr), .wdata(wdata),
        .tmr_done(tmr_done), .tmr_start(tmr_start), .tmr_dur(tmr_dur),
        .state(state), .busy(busy), .row_q(row_q), .col_q(col_q), .wr_q(wr_q),
        .wdata_q(wdata_q), .load_row(load_row), .access_en(access_en),
        .write_back(write_back)
    );

    drs_phase_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .dur(tmr_dur), .done(tmr_done)
    );

    drs_bank #(.AB(AB), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .row(row_q), .col(col_q), .wr(wr_q),
        .wdata(wdata_q), .load_row(load_row), .access_en(access_en),
        .write_back(write_back), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign phase = state;

    AST_RDV_IN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (phase == 3'd6 && $past(phase) == 3'd5)); // R4
endmodule

// File: tb/dram_row_seq_test.sv
module dram_row_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AB = 3, DW = 8, TP = 2, TA = 1, TS = 2, TR = 4;
    localparam int N = 1 << AB;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
    logic [AB-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic busy, rd_valid;
    logic [2:0] phase;
    logic [DW-1:0] rd_data;

    int checks = 0, errors = 0;
    logic [DW-1:0] refm [N][N];
    logic [DW-1:0] expq [$];
    string tagq [$];

    dram_row_seq #(.AB(AB), .DW(DW), .T_PRE(TP), .T_ACT(TA), .T_SENSE(TS),
                   .T_RESTORE(TR)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .refresh_req(refresh_req), .addr(addr), .wdata(wdata), .busy(busy),
        .phase(phase), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on every read strobe.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (expq.size() == 0) chk(1'b0, "R9", "unexpected rd_valid", 1, 0);
            else begin
                automatic logic [DW-1:0] e = expq.pop_front();
                automatic string t = tagq.pop_front();
                chk(rd_data == e, t, "read data", int'(rd_data), int'(e));
            end
        end
    end

    // Driver: issue one operation and trace its phases at each falling edge.
    task automatic run_op(input bit refr, input bit both, input bit wr,
                          input int row, input int col, input logic [DW-1:0] d,
                          input bit poke, input string tag);
        int exp_ph [$];
        int n = 0, bad = 0, nbusy = 0;
        if (!refr) exp_ph.push_back(1);
        repeat (TP) exp_ph.push_back(2);
        repeat (TA) exp_ph.push_back(3);
        repeat (TS) exp_ph.push_back(4);
        if (!refr) exp_ph.push_back(5);
        repeat (TR) exp_ph.push_back(6);
        @(negedge clk);
        refresh_req = refr;
        req_valid   = !refr || both;
        req_write   = wr;
        addr        = AB'(row);
        @(negedge clk);
        refresh_req = 1'b0;
        req_valid   = 1'b0;
        addr        = AB'(col);
        wdata       = d;
        if (!refr && !wr) begin
            expq.push_back(refm[row][col]);
            tagq.push_back(tag);
        end
        if (!refr && wr) refm[row][col] = d;
        while (phase != 3'd0 && n < 100) begin
            if (n >= exp_ph.size() || int'(phase) != exp_ph[n]) bad++;
            if (busy) nbusy++;
            if (poke && phase == 3'd2) begin
                req_valid = 1'b1; req_write = 1'b1; addr = '0; wdata = 8'hEE;
            end
            if (poke && phase == 3'd6) req_valid = 1'b0;
            n++;
            @(negedge clk);
        end
        chk(bad == 0 && n == exp_ph.size(), refr ? "R9" : "R3", "phase trace",
            n, exp_ph.size());
        chk(nbusy == exp_ph.size() && !busy, "R7", "busy cycles", nbusy, exp_ph.size());
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R7", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) refm[r][c] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(phase == 3'd0, "R1", "phase after reset", int'(phase), 0);
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        // R1: bank cleared
        run_op(0, 0, 0, 5, 2, '0, 0, "R1");
        // R6: fill a row, overwrite one column, read all back
        for (int c = 0; c < N; c++) run_op(0, 0, 1, 3, c, DW'(8'h30 + c), 0, "R6");
        run_op(0, 0, 1, 3, 4, 8'hA5, 0, "R6");
        for (int c = 0; c < N; c++) run_op(0, 0, 0, 3, c, '0, 0, "R6");
        // R5: repeated reads survive the destructive open
        repeat (3) run_op(0, 0, 0, 3, 4, '0, 0, "R5");
        // R2: row and column halves are not swapped
        run_op(0, 0, 1, 2, 5, 8'h5C, 0, "R2");
        run_op(0, 0, 1, 5, 2, 8'hC5, 0, "R2");
        run_op(0, 0, 0, 2, 5, '0, 0, "R2");
        run_op(0, 0, 0, 5, 2, '0, 0, "R2");
        // R8: write attempted while busy is dropped
        run_op(0, 0, 0, 3, 1, '0, 1, "R4");
        run_op(0, 0, 0, 0, 0, '0, 0, "R8");
        run_op(0, 0, 0, 0, 7, '0, 0, "R8");
        // R9: refresh keeps data, wins over a simultaneous host request
        run_op(1, 0, 0, 3, 0, '0, 0, "R9");
        run_op(0, 0, 0, 3, 4, '0, 0, "R9");
        run_op(1, 1, 1, 2, 5, 8'h99, 0, "R9");
        run_op(0, 0, 0, 2, 5, '0, 0, "R9");
        repeat (4) @(negedge clk);
        // R4: every expected read strobe arrived
        chk(expq.size() == 0, "R4", "pending reads", expq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule